// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request port and an external 64K-word by 24-bit asynchronous static RAM. It accepts one read or one write per request. For each request it produces the strobe pattern that the memory expects: a paired active-low and active-high device select, an active-low read enable, an active-low write pulse, the word address and the bank-control line. It also drives the bus direction and samples the returned read word. Every interval is a whole number of clock cycles, fixed by parameters rounded up from the nanosecond limits of the chosen speed grade.

The uppermost index bit is not always taken from the address. A bank-control output picks, per access, whether the memory uses the top address line or a separate vector bit as its top index bit. The sequencer treats the bank-control and vector outputs exactly like address lines: valid from the setup cycle until after the write pulse ends. The data bus is split into an output word with its own enable and an input word. A read is always separated from a following bus drive by one fully released cycle.

Top module: `asram_seq_top`

## Requirements
- R1: While reset is low and after it is released, the device is deselected (memSelLoN high, memSelHi low), memRdEnN and memWrEnN are high, memDqOe and rdValid are low, and ready is high.
- R2: A request is taken only at a rising clock edge where reqValid and ready are both high. ready is high in the idle state, in the final cycle of a read and in the write hold cycle. The request fields are copied at that edge, and changing them afterwards leaves the running access unchanged.
- R3: For a read, the device is selected with memRdEnN low and memWrEnN high for ACC_CYC cycles. The word on memDqIn in the last of these cycles appears on rdData, with rdValid high for one cycle, in the (ACC_CYC+2)-th cycle after the accepting edge.
- R4: For a write, one setup cycle (device selected, memWrEnN high, address already valid) is followed by exactly PULSE_CYC cycles of memWrEnN low with memRdEnN high, and then by one hold cycle with the device still selected.
- R5: The write word is driven (memDqOe high) in at least the last SETUP_CYC cycles of the write pulse and in the hold cycle. It does not change while it is driven.
- R6: memDqOe is never high in a cycle where the memory is selected with memRdEnN low.
- R7: Between the last cycle of a read and the next cycle with memDqOe high there is at least one cycle with the device deselected and memDqOe low.
- R8: memBankCtl and memVec repeat the request's reqBankCtl and reqVec. With memBankCtl high, the memory's top index bit is memVec and memAddr's top bit has no effect. With it low, the top index bit is memAddr[ADDR_W-1].
- R9: memAddr, memBankCtl and memVec stay constant from the setup cycle through the end of the write pulse.
- R10: A read accepted in the last cycle of a previous read keeps the device selected with no gap. Back-to-back reads then return rdValid pulses exactly ACC_CYC cycles apart, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrN | input | 1 | Request kind: low = write, high = read |
| reqAddr | input | ADDR_W | Word address of the request |
| reqBankCtl | input | 1 | Top index bit source: 1 = reqVec, 0 = reqAddr top bit |
| reqVec | input | 1 | Vector bit used when reqBankCtl is high |
| reqWdata | input | DATA_W | Write word |
| ready | output | 1 | Request can be taken this cycle |
| rdData | output | DATA_W | Captured read word |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |
| memAddr | output | ADDR_W | Memory address lines |
| memSelLoN | output | 1 | Active-low device select |
| memSelHi | output | 1 | Active-high device select |
| memRdEnN | output | 1 | Active-low memory output enable |
| memWrEnN | output | 1 | Active-low write pulse |
| memBankCtl | output | 1 | Memory top index bit source control |
| memVec | output | 1 | Memory vector bit |
| memDqOut | output | DATA_W | Word driven onto the memory bus |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | DATA_W | Word sampled from the memory bus |

## Verification
Suppose the sequencer state or its interval counter is corrupted. The pulse then has the wrong length, or the write word is driven too late, and this shows on the pins inside the same access: a wrong run length of memWrEnN, memDqOe low at the rising write edge, or memDqOe high against an enabled read. A wrong bank-control or vector latch writes a word to the other half of the array. That does not show until the half-swapped index is read back, so both selection modes are swept over every index and read back through the other mode. A stale hold register shows as a wrong rdData word, or as a shifted rdValid pulse, within ACC_CYC+2 cycles of the read.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WHLD
  } seq_state_e;

  // Strobes passed from control to datapath, registered there onto the pins.
  typedef struct packed {
    logic select;
    logic readEn;
    logic writeEn;
    logic driveBus;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ACC_CYC   = 1,
  parameter int PULSE_CYC = 1,
  parameter int SETUP_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrN,
  output logic    ready,
  output logic    load,
  output strobe_t strb
);

  localparam int MAX_CYC = (ACC_CYC > PULSE_CYC) ? ACC_CYC : PULSE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LOAD   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LIM  = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  if (ACC_CYC < 1 || PULSE_CYC < 1 || SETUP_CYC < 1 || SETUP_CYC > PULSE_CYC) begin : g_bad_timing
    $error("asram_ctrl: interval parameters out of range");
  end

  seq_state_e curSt, nxtSt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic lastCyc;

  assign lastCyc = (cnt == '0);

  // R2: acceptance points
  assign ready = (curSt == ST_IDLE) || ((curSt == ST_READ) && lastCyc) || (curSt == ST_WHLD);
  assign load  = reqValid && ready;

  always_comb begin
    nxtSt  = curSt;
    cntNxt = cnt;
    unique case (curSt)
      ST_IDLE: ;
      ST_READ: begin
        if (!lastCyc) cntNxt = cnt - CNT_ONE;
        else          nxtSt  = ST_IDLE;
      end
      ST_TURN: nxtSt = ST_WSET;
      ST_WSET: begin
        nxtSt  = ST_WPUL;
        cntNxt = PULSE_LOAD;
      end
      ST_WPUL: begin
        if (!lastCyc) cntNxt = cnt - CNT_ONE;
        else          nxtSt  = ST_WHLD;
      end
      ST_WHLD: nxtSt = ST_IDLE;
      default: nxtSt = ST_IDLE;
    endcase
    if (load) begin
      if (reqWrN) begin
        nxtSt  = ST_READ;
        cntNxt = ACC_LOAD;
      end else begin
        // R7: a write straight after a read passes through a released cycle
        nxtSt = (curSt == ST_READ) ? ST_TURN : ST_WSET;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSt <= ST_IDLE;
      cnt   <= '0;
    end else begin
      curSt <= nxtSt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    strb.select   = (curSt == ST_READ) || (curSt == ST_WSET) ||
                    (curSt == ST_WPUL) || (curSt == ST_WHLD);
    strb.readEn   = (curSt == ST_READ);
    strb.writeEn  = (curSt == ST_WPUL);
    // R5: drive only the closing SETUP_CYC cycles of the pulse plus the hold cycle
    strb.driveBus = ((curSt == ST_WPUL) && (cnt < SETUP_LIM)) || (curSt == ST_WHLD);
    strb.capture  = (curSt == ST_READ) && lastCyc;
  end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBankCtl,
  input  logic              reqVec,
  input  logic [DATA_W-1:0] reqWdata,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelLoN,
  output logic              memSelHi,
  output logic              memRdEnN,
  output logic              memWrEnN,
  output logic              memBankCtl,
  output logic              memVec,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] holdAddr;
  logic              holdBank;
  logic              holdVec;
  logic [DATA_W-1:0] holdData;
  logic              capQ;

  // R2: request fields copied only at the accepting edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdBank <= 1'b0;
      holdVec  <= 1'b0;
      holdData <= '0;
    end else if (load) begin
      holdAddr <= reqAddr;
      holdBank <= reqBankCtl;
      holdVec  <= reqVec;
      holdData <= reqWdata;
    end
  end

  // Pin registers: address and strobes move together, one cycle behind state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr    <= '0;
      memBankCtl <= 1'b0;
      memVec     <= 1'b0;
      memDqOut   <= '0;
      memSelLoN  <= 1'b1;
      memSelHi   <= 1'b0;
      memRdEnN   <= 1'b1;
      memWrEnN   <= 1'b1;
      memDqOe    <= 1'b0;
      capQ       <= 1'b0;
    end else begin
      memAddr    <= holdAddr;
      memBankCtl <= holdBank;
      memVec     <= holdVec;
      memDqOut   <= holdData;
      memSelLoN  <= ~strb.select;
      memSelHi   <= strb.select;
      memRdEnN   <= ~strb.readEn;
      memWrEnN   <= ~strb.writeEn;
      memDqOe    <= strb.driveBus;
      capQ       <= strb.capture;
    end
  end

  // R3: sample the bus at the close of the final read cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= capQ;
      if (capQ) rdData <= memDqIn;
    end
  end

endmodule

// File: rtl/asram_seq_top.sv
module asram_seq_top
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 24,
  parameter int ACC_CYC   = 1,
  parameter int PULSE_CYC = 1,
  parameter int SETUP_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBankCtl,
  input  logic              reqVec,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelLoN,
  output logic              memSelHi,
  output logic              memRdEnN,
  output logic              memWrEnN,
  output logic              memBankCtl,
  output logic              memVec,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strb;
  logic    load;

  asram_ctrl #(
    .ACC_CYC  (ACC_CYC),
    .PULSE_CYC(PULSE_CYC),
    .SETUP_CYC(SETUP_CYC)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrN  (reqWrN),
    .ready   (ready),
    .load    (load),
    .strb    (strb)
  );

  asram_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .load      (load),
    .reqAddr   (reqAddr),
    .reqBankCtl(reqBankCtl),
    .reqVec    (reqVec),
    .reqWdata  (reqWdata),
    .strb      (strb),
    .memDqIn   (memDqIn),
    .memAddr   (memAddr),
    .memSelLoN (memSelLoN),
    .memSelHi  (memSelHi),
    .memRdEnN  (memRdEnN),
    .memWrEnN  (memWrEnN),
    .memBankCtl(memBankCtl),
    .memVec    (memVec),
    .memDqOut  (memDqOut),
    .memDqOe   (memDqOe),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memSelLoN,
  input logic              memSelHi,
  input logic              memRdEnN,
  input logic              memWrEnN,
  input logic              memBankCtl,
  input logic              memVec,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  p_no_clash_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !(!memSelLoN && memSelHi && !memRdEnN));

  p_write_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memWrEnN |-> (memRdEnN && !memSelLoN && memSelHi));

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!memWrEnN && !$past(memWrEnN)) |->
      ($stable(memAddr) && $stable(memBankCtl) && $stable(memVec)));

  p_hold_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrEnN) |-> (memDqOe && $past(memDqOe) && !memSelLoN));

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut));

  p_valid_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (!$past(memRdEnN) && !$past(memSelLoN)));

endmodule

bind asram_seq_top asram_seq_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .rdValid   (rdValid),
  .memAddr   (memAddr),
  .memSelLoN (memSelLoN),
  .memSelHi  (memSelHi),
  .memRdEnN  (memRdEnN),
  .memWrEnN  (memWrEnN),
  .memBankCtl(memBankCtl),
  .memVec    (memVec),
  .memDqOut  (memDqOut),
  .memDqOe   (memDqOe)
);

// File: tb/asram_seq_top_tb_top.sv
module asram_seq_top_tb_top;

  localparam int AW    = 8;
  localparam int DW    = 24;
  localparam int ACC   = 2;
  localparam int PULSE = 3;
  localparam int SETUP = 2;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrN = 1'b1;
  logic [AW-1:0] reqAddr = '0;
  logic          reqBankCtl = 1'b0;
  logic          reqVec = 1'b0;
  logic [DW-1:0] reqWdata = '0;
  logic          ready;
  logic [DW-1:0] rdData;
  logic          rdValid;
  logic [AW-1:0] memAddr;
  logic          memSelLoN, memSelHi, memRdEnN, memWrEnN, memBankCtl, memVec, memDqOe;
  logic [DW-1:0] memDqOut;
  logic [DW-1:0] memDqIn;

  always #4 clk = ~clk;

  asram_seq_top #(
    .ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrN(reqWrN), .reqAddr(reqAddr),
    .reqBankCtl(reqBankCtl), .reqVec(reqVec), .reqWdata(reqWdata), .ready(ready),
    .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr), .memSelLoN(memSelLoN),
    .memSelHi(memSelHi), .memRdEnN(memRdEnN), .memWrEnN(memWrEnN),
    .memBankCtl(memBankCtl), .memVec(memVec), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model driven from the pins ----------------
  logic [DW-1:0] model [WORDS];
  logic          devSel, memDrives;
  logic [AW-1:0] pinIdx;
  logic          wrPend = 1'b0;
  logic [AW-1:0] pendIdx = '0;
  logic [DW-1:0] pendData = '0;

  assign devSel    = !memSelLoN && memSelHi;
  // R8: top index bit taken from memVec when memBankCtl is high
  assign pinIdx    = memBankCtl ? {memVec, memAddr[AW-2:0]} : memAddr;
  assign memDrives = devSel && !memRdEnN && memWrEnN;
  assign memDqIn   = memDrives ? model[pinIdx] : 24'h5A5A5A;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (devSel && !memWrEnN) begin
      wrPend   <= 1'b1;
      pendIdx  <= pinIdx;
      pendData <= memDqOe ? memDqOut : 24'hBADBAD;
    end else if (wrPend) begin
      model[pendIdx] <= pendData;
      wrPend <= 1'b0;
    end
  end

  // ---------------- expected-value bookkeeping ----------------
  logic [DW-1:0] shadow [WORDS];
  logic [DW-1:0] expQ [1024];
  string         tagQ [1024];
  int wrIdx = 0;
  int rdIdx = 0;
  bit burstMode = 1'b0;
  bit burstFirst = 1'b0;
  int prevValidCyc = 0;

  function automatic logic [DW-1:0] pat(input int idx, input int seed);
    return DW'((idx * 32'h0001_03F3) ^ (seed * 32'h00A5_0B07) ^ 32'h0000_3C5A);
  endfunction

  function automatic logic [AW-1:0] effIdx(input logic [AW-1:0] a, input bit bank, input bit vec);
    return bank ? {vec, a[AW-2:0]} : a;
  endfunction

  // ---------------- pin monitor ----------------
  bit weLowPrev = 1'b0, prevSel = 1'b0, prevWeN = 1'b1, needGap = 1'b0, addrBad = 1'b0;
  bit prevBank = 1'b0, prevVec = 1'b0, prevDqOe = 1'b0;
  logic [AW-1:0] prevAddr = '0, runAddr = '0;
  int lowRun = 0, drvRun = 0;

  always @(negedge clk) begin
    if (rstN) begin
      bit weLow;
      weLow = devSel && !memWrEnN;
      if (memDrives) check(!memDqOe, "R6", "bus driven during enabled read", 1, 0);
      if (memDqOe && !prevDqOe)
        check(!needGap, "R7", "no released cycle between read and drive", 0, 1);
      if (memDrives) needGap = 1'b1;
      else if (!devSel && !memDqOe) needGap = 1'b0;
      if (weLow) begin
        if (!weLowPrev) begin
          check(prevSel && prevWeN && prevAddr == memAddr && prevBank == memBankCtl &&
                prevVec == memVec, "R4", "setup cycle before write pulse", 0, 1);
          lowRun = 0; drvRun = 0; runAddr = memAddr;
        end
        lowRun++;
        if (memDqOe) drvRun++;
        if (!memRdEnN || memAddr != runAddr || memBankCtl != prevBank || memVec != prevVec)
          addrBad = 1'b1;
      end else if (weLowPrev) begin
        check(lowRun == PULSE, "R4", "write pulse length", lowRun, PULSE);
        check(devSel && memDqOe, "R4", "hold cycle selected and driven", 0, 1);
        check(drvRun >= SETUP, "R5", "drive cycles before write edge", drvRun, SETUP);
        check(!addrBad, "R9", "address/bank/vector stable over write", 1, 0);
        addrBad = 1'b0;
      end
      if (rdValid) begin
        if (rdIdx < wrIdx) begin
          check(rdData == expQ[rdIdx], tagQ[rdIdx], "read word", rdData, expQ[rdIdx]);
          rdIdx++;
        end else check(1'b0, "R3", "unexpected rdValid", 1, 0);
        if (burstMode) begin
          if (!burstFirst)
            check(cyc - prevValidCyc == ACC, "R10", "back-to-back spacing", cyc - prevValidCyc, ACC);
          burstFirst = 1'b0;
        end
        prevValidCyc = cyc;
      end
      weLowPrev = weLow; prevSel = devSel; prevWeN = memWrEnN; prevAddr = memAddr;
      prevBank = memBankCtl; prevVec = memVec; prevDqOe = memDqOe;
    end
  end

  // ---------------- request tasks (called at a negedge) ----------------
  task automatic issue(input bit isWr, input logic [AW-1:0] a, input bit bank,
                       input bit vec, input logic [DW-1:0] d);
    bit r;
    reqWrN = !isWr; reqAddr = a; reqBankCtl = bank; reqVec = vec; reqWdata = d;
    reqValid = 1'b1;
    forever begin
      r = ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    // R2: scramble fields after acceptance; the access must not change
    reqValid = 1'b0; reqAddr = ~a; reqBankCtl = !bank; reqVec = !vec; reqWdata = ~d;
    reqWrN = isWr;
  endtask

  task automatic wr(input logic [AW-1:0] a, input bit bank, input bit vec, input logic [DW-1:0] d);
    shadow[effIdx(a, bank, vec)] = d;
    issue(1'b1, a, bank, vec, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit bank, input bit vec,
                    input string tag, input bit serial);
    int lat;
    expQ[wrIdx] = shadow[effIdx(a, bank, vec)];
    tagQ[wrIdx] = tag;
    wrIdx++;
    issue(1'b0, a, bank, vec, '0);
    if (serial) begin
      check(!ready, "R2", "ready low inside read", ready, 0);
      lat = 1;
      while (!rdValid && lat < 20) begin
        @(negedge clk);
        lat++;
      end
      check(lat == ACC + 2, "R3", "read latency", lat, ACC + 2);
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && rdIdx < wrIdx; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (120000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    check(memSelLoN && !memSelHi, "R1", "deselected in reset", {memSelLoN, memSelHi}, 2);
    check(memRdEnN && memWrEnN, "R1", "enables idle in reset", {memRdEnN, memWrEnN}, 3);
    check(!memDqOe && !rdValid, "R1", "bus and valid idle in reset", {memDqOe, rdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ready, "R1", "ready after reset", ready, 1);
    check(memSelLoN && !memSelHi && memRdEnN && memWrEnN && !memDqOe, "R1",
          "pins idle after reset", 0, 1);

    // direct mode: full sweep write then read
    for (int a = 0; a < WORDS; a++) wr(AW'(a), 1'b0, 1'b0, pat(a, 1));
    for (int a = 0; a < WORDS; a++) rd(AW'(a), 1'b0, 1'b0, "R3", 1'b1);
    drain();

    // vector mode: top address bit inverted and must be ignored
    for (int i = 0; i < WORDS; i++) begin
      logic [AW-1:0] ix;
      ix = AW'(i);
      wr({~ix[AW-1], ix[AW-2:0]}, 1'b1, ix[AW-1], pat(i, 2));
    end
    for (int i = 0; i < WORDS; i++) rd(AW'(i), 1'b0, 1'b0, "R8", 1'b1);
    for (int i = 0; i < WORDS; i += 3) begin
      logic [AW-1:0] ix;
      ix = AW'(i);
      rd({~ix[AW-1], ix[AW-2:0]}, 1'b1, ix[AW-1], "R8", 1'b0);
    end
    drain();

    // back-to-back reads
    burstMode = 1'b1; burstFirst = 1'b1;
    for (int i = 0; i < 24; i++) rd(AW'(i * 7), 1'b0, 1'b0, "R10", 1'b0);
    drain();
    burstMode = 1'b0;

    // read immediately followed by write, then read back
    for (int i = 0; i < 32; i++) begin
      logic [AW-1:0] ix;
      ix = AW'(i * 5 + 3);
      rd(ix, 1'b0, 1'b0, "R7", 1'b0);
      wr(ix, i[0], ix[AW-1], pat(i, 3));
      rd(ix, 1'b0, 1'b0, "R7", 1'b1);
    end
    drain();
    check(rdIdx == wrIdx, "R3", "all reads returned", rdIdx, wrIdx);
    summary();
    $finish;
  end

endmodule